// File: doc/BRIEF.md
# Parallel EEPROM Page-Load Emulator

This block is a synthesizable behavioural model of the device side of an asynchronous byte-wide EEPROM. It runs on a fast system clock and samples the active-low chip-enable, output-enable and write-enable strobes, the address bus and the write data bus. Reads are served from an internal byte array through a registered data output and a tri-state enable. Writes are collected into a page buffer that has one valid flag per byte. A load window, counted in clock cycles, ends the page. A busy period then follows, during which only the flagged bytes are copied into the array.

The strobes carry no back-pressure. A strobe that arrives while the block is busy is simply dropped, so the host has to watch `busy` before it starts a new load. The full device has a 17-bit address. `ADDR_W` sets the array size, and the default builds a smaller array so that elaboration stays light. The low `OFF_W` address bits select a byte within a page, and the remaining upper bits select the page. After reset the block spends one busy sweep setting every array byte to the erased value 0xFF.

Top module: `eep_page_emu`

## Requirements
- R1: While `ce_n`=0, `oe_n`=0, `we_n`=1 and `busy`=0 are held, `dout_en` goes to 1 and `dout` carries the array byte at `addr` two clock edges after the inputs were applied. With `ce_n`=1 or `oe_n`=1, `dout_en` is 0.
- R2: A write pulse is the interval in which `ce_n` and `we_n` are both 0 while `oe_n` is 1. If `oe_n` is 0 during such an overlap, no byte is loaded and no load window starts.
- R3: The address of a write is the value present when the later of the two strobes falls, which is when the write pulse begins.
- R4: The data of a write is the value present just before the earlier of the two strobes rises, which is when the write pulse ends.
- R5: `addr[OFF_W-1:0]` selects the byte within the page. All 2^OFF_W bytes (128 by default) can be loaded in one page, in any order. A byte loaded twice keeps its last value.
- R6: Each accepted byte restarts the load window. If no further byte is accepted, `busy` rises WIN_CYC+2 clock edges after the strobe edge that ended the last write pulse.
- R7: When programming finishes, only the bytes loaded in that page hold new values. Every other array byte keeps its previous value.
- R8: The first byte of a load fixes the page, `addr[ADDR_W-1:OFF_W]`. A later byte whose page differs sets `page_err` to 1 and is discarded. `page_err` returns to 0 when the busy period ends.
- R9: `busy` stays high for exactly PROG_CYC clock cycles. During that time `dout_en` stays 0, and write pulses have no effect, either at the time or afterwards.
- R10: During reset and the erase sweep that follows it, `busy` is 1 and `dout_en` is 0. Afterwards every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in upper bits, offset in low OFF_W bits |
| din | input | DATA_W | Write data from the host |
| dout | output | DATA_W | Read data toward the host |
| dout_en | output | 1 | Drive enable for the host-side tri-state buffer |
| busy | output | 1 | Erase sweep or page programming in progress |
| page_err | output | 1 | A byte from a different page was refused in this load |

## Verification
The bench builds the block with ADDR_W=11, WIN_CYC=40 and PROG_CYC=160. These values keep the erase sweep at 2048 cycles and make each load window and each programming period short enough to run a dozen of them. With them, the bench can check window expiry to the exact cycle, the restart of the window by spaced bytes, a full 128-byte page, and strobes that arrive in the middle of a busy period. The 16 pages available let every scenario work on its own page, so a stray write would show up as a changed byte elsewhere.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_INIT,  // erase sweep after reset
    ST_IDLE,  // no load open
    ST_LOAD,  // page buffer collecting bytes
    ST_PROG   // committing flagged bytes
  } eep_state_e;
endpackage

// File: rtl/eep_strobe_dec.sv
// Registers the asynchronous bus and finds the start and end of write pulses.
module eep_strobe_dec #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              block,
  output logic              rd_act,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_end,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic ce_q, oe_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, data_prev;
  logic wr_act, wr_prev, armed, wr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q      <= 1'b1;
      oe_q      <= 1'b1;
      we_q      <= 1'b1;
      addr_q    <= '0;
      data_q    <= '0;
      data_prev <= '0;
    end else begin
      ce_q      <= ce_n;
      oe_q      <= oe_n;
      we_q      <= we_n;
      addr_q    <= addr;
      data_q    <= din;
      data_prev <= data_q;
    end
  end

  // a write is the overlap of both low strobes with output enable high
  assign wr_act   = !ce_q && !we_q && oe_q;
  assign wr_start = wr_act && !wr_prev && !block;
  assign wr_end   = !wr_act && wr_prev && armed && !block;
  assign wr_data  = data_prev;
  assign rd_act   = !ce_q && !oe_q && we_q;
  assign rd_addr  = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      armed   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_prev <= wr_act;
      if (block)          armed <= 1'b0;
      else if (wr_start)  armed <= 1'b1;
      else if (wr_end)    armed <= 1'b0;
      if (wr_start) wr_addr <= addr_q;
    end
  end

  // R2: a pulse can only be armed while the strobe overlap is still seen
  assert_armed_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> wr_prev);
endmodule

// File: rtl/eep_page_buf.sv
// One page of staged bytes with a valid flag per slot.
module eep_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE_SZ = 1 << OFF_W;

  logic [DATA_W-1:0] slot [PAGE_SZ];
  logic [PAGE_SZ-1:0] vld;

  for (genvar g = 0; g < PAGE_SZ; g++) begin : g_slot
    localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(g);
    always_ff @(posedge clk) begin
      if (wr_en && wr_off == MY_OFF) slot[g] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          vld[g] <= 1'b0;
      else if (clr)                        vld[g] <= 1'b0;
      else if (wr_en && wr_off == MY_OFF)  vld[g] <= 1'b1;
    end
  end

  assign rd_vld  = vld[rd_off];
  assign rd_data = slot[rd_off];

  // R9: nothing is staged in the cycle the page is released
  assert_no_load_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr));
endmodule

// File: rtl/eep_load_timer.sv
// Counts the inter-byte load window; restarts on every accepted byte.
module eep_load_timer #(
  parameter int WIN_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end

  assign expire = run && !restart && cnt == LAST;

  // R6: the count never runs past the window
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R6: a window can only close after it was open on the previous cycle
  assert_expire_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(run));
endmodule

// File: rtl/eep_page_emu.sv
// Device-side EEPROM model: reads, page loads, timed commit.
module eep_page_emu
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 7,
  parameter int WIN_CYC  = 15000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_SZ = 1 << OFF_W;
  localparam int PAGE_W  = ADDR_W - OFF_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PROG_W  = $clog2(PROG_CYC + 1);
  localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYC - 1);
  localparam logic [PROG_W-1:0] PAGE_END  = PROG_W'(PAGE_SZ);

  eep_state_e state;
  logic rd_act, wr_end, acc, mism, tmr_exp, pb_vld, pb_clr, prog_last, prog_wr;
  logic [ADDR_W-1:0] rd_addr, wr_addr, init_idx;
  logic [DATA_W-1:0] wr_data, pb_data;
  logic [PAGE_W-1:0] page_reg, wr_page;
  logic [OFF_W-1:0]  wr_off, prog_off;
  logic [PROG_W-1:0] prog_cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  assign busy = (state == ST_INIT) || (state == ST_PROG);

  eep_strobe_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .block(busy),
    .rd_act(rd_act), .rd_addr(rd_addr),
    .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign wr_page = wr_addr[ADDR_W-1:OFF_W];
  assign wr_off  = wr_addr[OFF_W-1:0];
  assign acc  = wr_end && ((state == ST_IDLE) ||
                           (state == ST_LOAD && wr_page == page_reg));
  assign mism = wr_end && state == ST_LOAD && wr_page != page_reg;

  eep_load_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state == ST_LOAD), .restart(acc),
    .expire(tmr_exp)
  );

  assign prog_off  = prog_cnt[OFF_W-1:0];
  assign prog_last = prog_cnt == PROG_LAST;
  assign pb_clr    = state == ST_PROG && prog_last;

  eep_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(acc), .wr_off(wr_off),
    .wr_data(wr_data), .clr(pb_clr), .rd_off(prog_off),
    .rd_vld(pb_vld), .rd_data(pb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      init_idx <= '0;
      prog_cnt <= '0;
      page_reg <= '0;
      page_err <= 1'b0;
    end else begin
      case (state)
        ST_INIT: begin
          init_idx <= init_idx + 1'b1;
          if (init_idx == {ADDR_W{1'b1}}) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (acc) begin
            page_reg <= wr_page;
            state    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (mism) page_err <= 1'b1;
          if (tmr_exp) begin
            state    <= ST_PROG;
            prog_cnt <= '0;
          end
        end
        ST_PROG: begin
          prog_cnt <= prog_cnt + 1'b1;
          if (prog_last) begin
            state    <= ST_IDLE;
            page_err <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // one buffer slot is visited per busy cycle; unflagged slots are skipped
  assign prog_wr = state == ST_PROG && prog_cnt < PAGE_END && pb_vld;

  always_ff @(posedge clk) begin
    if (state == ST_INIT) mem[init_idx] <= '1;
    else if (prog_wr)     mem[{page_reg, prog_off}] <= pb_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      dout_en <= rd_act && !busy;
      dout    <= mem[rd_addr];
    end
  end

  // R9: the read driver stays off once busy has been seen
  assert_oe_off_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !dout_en);
  // R9: programming always ends after the full count
  assert_prog_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_PROG && state == ST_IDLE) |-> $past(prog_cnt) == PROG_LAST);
  // R8: the page of an open load does not move
  assert_page_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(page_reg));
endmodule

// File: tb/eep_page_emu_tb.sv
module eep_page_emu_tb;
  localparam int AW   = 11;
  localparam int DW   = 8;
  localparam int WIN  = 40;
  localparam int PROG = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy, page_err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eep_page_emu #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(7),
                 .WIN_CYC(WIN), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .page_err(page_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b0;
    tick(3);
    we_n = 1'b1; ce_n = 1'b1;
    tick(2);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic en);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    tick(3);
    v = dout; en = dout_en;
    ce_n = 1'b1; oe_n = 1'b1;
    tick(1);
  endtask

  task automatic wait_busy(input bit lvl, output int n);
    n = 0;
    while (busy != lvl && n < 5000) begin
      tick(1);
      n++;
    end
  endtask

  task automatic expect_byte(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
    logic [DW-1:0] v;
    logic en;
    rd_byte(a, v, en);
    chk(en == 1'b1, req, int'(en), 1);
    chk(v == e, req, int'(v), int'(e));
  endtask

  task automatic t_reset();
    int n;
    tick(5);
    chk(busy == 1'b1, "R10 busy in reset", int'(busy), 1);
    chk(dout_en == 1'b0, "R10 dout_en in reset", int'(dout_en), 0);
    chk(page_err == 1'b0, "R8 page_err in reset", int'(page_err), 0);
    rst_n = 1'b1;
    tick(3);
    chk(busy == 1'b1, "R10 busy during sweep", int'(busy), 1);
    wait_busy(1'b0, n);
    chk(busy == 1'b0, "R10 sweep ends", int'(busy), 0);
    expect_byte(11'h000, 8'hFF, "R10 erased low");
    expect_byte(11'h7FF, 8'hFF, "R10 erased high");
  endtask

  task automatic t_read_gating();
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 11'h010;
    tick(3);
    chk(dout_en == 1'b0, "R1 oe high no drive", int'(dout_en), 0);
    ce_n = 1'b1; oe_n = 1'b0;
    tick(3);
    chk(dout_en == 1'b0, "R1 ce high no drive", int'(dout_en), 0);
    oe_n = 1'b1;
    tick(1);
  endtask

  task automatic t_byte_write();
    int k, len;
    wr_byte(11'h085, 8'h3C);
    wait_busy(1'b1, k);
    chk(k == WIN, "R6 window expiry cycle", k, WIN);
    len = 0;
    while (busy && len < 5000) begin
      tick(1);
      len++;
    end
    chk(len == PROG, "R9 busy length", len, PROG);
    expect_byte(11'h085, 8'h3C, "R1 R7 written byte");
    expect_byte(11'h084, 8'hFF, "R7 neighbour untouched");
  endtask

  task automatic t_any_order();
    int n;
    wr_byte(11'h18A, 8'hA1);
    tick(25);
    wr_byte(11'h182, 8'hB2);
    tick(25);
    wr_byte(11'h18A, 8'hC3);
    tick(25);
    chk(busy == 1'b0, "R6 window restarted", int'(busy), 0);
    wr_byte(11'h1FF, 8'hD4);
    wait_busy(1'b1, n);
    wait_busy(1'b0, n);
    expect_byte(11'h18A, 8'hC3, "R5 overwrite keeps last");
    expect_byte(11'h182, 8'hB2, "R5 out of order byte");
    expect_byte(11'h1FF, 8'hD4, "R5 last offset");
    expect_byte(11'h183, 8'hFF, "R7 unloaded byte");
  endtask

  task automatic t_full_page();
    int n, bad;
    logic [DW-1:0] v;
    logic en;
    for (int i = 127; i >= 0; i--) wr_byte(AW'(11'h280 + i), DW'(i) ^ 8'h5A);
    wait_busy(1'b1, n);
    wait_busy(1'b0, n);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      rd_byte(AW'(11'h280 + i), v, en);
      if (!en || v != (DW'(i) ^ 8'h5A)) bad++;
    end
    chk(bad == 0, "R5 full page of 128", bad, 0);
  endtask

  task automatic t_ce_controlled();
    int n;
    addr = 11'h340; din = 8'h55; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1;
    tick(2);
    addr = 11'h305; din = 8'h11; ce_n = 1'b0;
    tick(3);
    addr = 11'h340; din = 8'h22; ce_n = 1'b1;
    tick(2);
    we_n = 1'b1;
    tick(2);
    wait_busy(1'b1, n);
    wait_busy(1'b0, n);
    expect_byte(11'h305, 8'h11, "R3 R4 later fall, first rise");
    expect_byte(11'h340, 8'hFF, "R3 early address not used");
  endtask

  task automatic t_oe_low_write();
    addr = 11'h400; din = 8'h77; oe_n = 1'b0; we_n = 1'b0; ce_n = 1'b0;
    tick(3);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(WIN + 10);
    chk(busy == 1'b0, "R2 no load with oe low", int'(busy), 0);
    expect_byte(11'h400, 8'hFF, "R2 byte not written");
  endtask

  task automatic t_page_mismatch();
    int n;
    wr_byte(11'h480, 8'h12);
    chk(page_err == 1'b0, "R8 no error first byte", int'(page_err), 0);
    wr_byte(11'h502, 8'h34);
    chk(page_err == 1'b1, "R8 error raised", int'(page_err), 1);
    wait_busy(1'b1, n);
    chk(page_err == 1'b1, "R8 error held in busy", int'(page_err), 1);
    wait_busy(1'b0, n);
    chk(page_err == 1'b0, "R8 error cleared", int'(page_err), 0);
    expect_byte(11'h480, 8'h12, "R8 own page byte");
    expect_byte(11'h502, 8'hFF, "R8 foreign byte dropped");
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [DW-1:0] v;
    logic en;
    wr_byte(11'h600, 8'h01);
    wait_busy(1'b1, n);
    tick(5);
    rd_byte(11'h600, v, en);
    chk(en == 1'b0, "R9 no drive when busy", int'(en), 0);
    wr_byte(11'h601, 8'h99);
    wait_busy(1'b0, n);
    tick(WIN + 10);
    chk(busy == 1'b0, "R9 busy write opened no load", int'(busy), 0);
    expect_byte(11'h601, 8'hFF, "R9 busy write ignored");
    expect_byte(11'h600, 8'h01, "R7 prior byte kept");
  endtask

  initial begin
    t_reset();
    t_read_gating();
    t_byte_write();
    t_any_order();
    t_full_page();
    t_ce_controlled();
    t_oe_low_write();
    t_page_mismatch();
    t_busy_ignore();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule